// File: doc/BRIEF.md
# Triggered DAC Data-Transfer Controller

This block is the digital front end of one converter channel. Bus writes land in a holding register in one of six word formats. Three formats are single-channel and three are dual-channel. Each format is normalised to a 12-bit code. The code then moves into a read-only output register that feeds the analog converter.

The move can happen in three ways. With triggering off, the output follows the holding value one clock later. With triggering on, the move waits for a selected event: a rising edge on one of six timer pulses or on one external line, or a self-clearing software bit. On each triggered load, an add-on value from an optional wave generator is added to the code, and the sum saturates at full scale.

Each hardware trigger can raise a DMA request. A request is not queued. If a second hardware trigger arrives while the first request is still unacknowledged, an underrun is flagged, DMA service stops, and the flag can drive an interrupt. The parameter `CH_IDX` picks which half of a dual-channel word the instance takes.

Top module: `dac_fe_top`

## Requirements
- R1: While and after reset, `dor_o`, `swtrig_o`, `dma_req_o`, `udr_flag_o` and `irq_o` are 0.
- R2: On `hold_we_i`, the format code sets how the holding value is taken from `hold_wdata_i`:
  - code 0 takes bits 11:0;
  - code 1 takes bits 15:4;
  - code 2 takes bits 7:0 and places them at holding bits 11:4, with bits 3:0 set to zero.
  - Codes 6 and 7 leave the holding value unchanged.
- R3: The dual-channel codes take fields that depend on `CH_IDX`:
  - code 3 takes bits 11:0 (`CH_IDX`=0) or 27:16 (`CH_IDX`=1);
  - code 4 takes bits 15:4 or 31:20;
  - code 5 takes bits 7:0 or 15:8, placed in holding bits 11:4 with bits 3:0 zero.
- R4: With triggering disabled, `dor_o` equals the holding value from one clock earlier, and `wave_add_i` has no effect.
- R5: With triggering enabled and select codes 0..6 (code n watches `hw_trig_i[n]`), `dor_o` loads on the third clock edge after a rising edge of the selected input is sampled. Unselected inputs, and a level held high, cause no load.
- R6: With select code 7, `swtrig_set_i` sets `swtrig_o`. One clock later the output loads and `swtrig_o` clears.
- R7: A triggered load stores the holding value plus `wave_add_i`, saturated at 0xFFF.
- R8: `dma_req_o` rises one clock after a sampled hardware trigger edge when DMA is enabled. It falls on `dma_ack_i`. A software trigger never raises it.
- R9: A hardware trigger edge while `dma_req_o` is high and not acknowledged does three things:
  - sets `udr_flag_o` and drops `dma_req_o`;
  - blocks further requests while the flag is set;
  - leaves conversions continuing.
- R10: `udr_clr_i` clears `udr_flag_o`. `irq_o` is high whenever the flag and the interrupt enable are both set.
- R11: A control write leaves the trigger select unchanged when the channel enable is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Channel enable |
| ctrl_trig_en_i | input | 1 | Trigger enable |
| ctrl_tsel_i | input | 3 | Trigger select (0..6 hardware, 7 software) |
| ctrl_dma_en_i | input | 1 | DMA enable |
| ctrl_udr_ie_i | input | 1 | Underrun interrupt enable |
| hold_we_i | input | 1 | Holding register write strobe |
| hold_fmt_i | input | 3 | Write format code |
| hold_wdata_i | input | 32 | Write data word |
| swtrig_set_i | input | 1 | Sets the software trigger bit |
| hw_trig_i | input | 7 | Timer pulses [5:0], external line [6] |
| wave_add_i | input | 12 | Add-on value from a wave generator |
| dma_ack_i | input | 1 | DMA acknowledge |
| udr_clr_i | input | 1 | Underrun flag clear (write-1) |
| dor_o | output | 12 | Output register to the converter |
| swtrig_o | output | 1 | Software trigger bit |
| dma_req_o | output | 1 | DMA request |
| udr_flag_o | output | 1 | DMA underrun flag |
| irq_o | output | 1 | Underrun interrupt |

## Verification
The assertions assume that all inputs are synchronous to `clk_i`. They also assume that `dma_ack_i` is pulsed only while a request is pending. The bench drives every input at the falling edge. It pulses the acknowledge only while `dma_req_o` is high. It changes the trigger select only through control writes, so that no false edge appears on a freshly selected source.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int DATA_W   = 12;
  localparam int NARROW_W = 8;
  localparam int BUS_W    = 32;
  localparam int HALF_W   = BUS_W / 2;
  localparam int TSEL_W   = 3;
  localparam int N_HW     = 7;
  localparam int TRIG_LAT = 3;

  typedef enum logic [2:0] {
    FMT_S12R = 3'd0,
    FMT_S12L = 3'd1,
    FMT_S8R  = 3'd2,
    FMT_D12R = 3'd3,
    FMT_D12L = 3'd4,
    FMT_D8R  = 3'd5
  } fmt_e;

  localparam logic [TSEL_W-1:0] TSEL_SW = '1;
endpackage

// File: rtl/dac_fmt_unpack.sv
module dac_fmt_unpack
  import dac_fe_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic             we_i,
  input  logic [2:0]       fmt_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             hold_we_o,
  output logic [DATA_W-1:0] hold_o
);
  localparam int R12_LO  = CH_IDX * HALF_W;
  localparam int L12_LO  = CH_IDX * HALF_W + HALF_W - DATA_W;
  localparam int R8_LO   = CH_IDX * NARROW_W;
  localparam int PAD_W   = DATA_W - NARROW_W;
  localparam int SL12_LO = HALF_W - DATA_W;

  always_comb begin
    hold_we_o = we_i;
    hold_o    = '0;
    unique case (fmt_i)
      FMT_S12R: hold_o = wdata_i[0 +: DATA_W];
      FMT_S12L: hold_o = wdata_i[SL12_LO +: DATA_W];
      FMT_S8R:  hold_o = {wdata_i[0 +: NARROW_W], {PAD_W{1'b0}}};
      FMT_D12R: hold_o = wdata_i[R12_LO +: DATA_W];
      FMT_D12L: hold_o = wdata_i[L12_LO +: DATA_W];
      FMT_D8R:  hold_o = {wdata_i[R8_LO +: NARROW_W], {PAD_W{1'b0}}};
      default:  hold_we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dac_trig_unit.sv
module dac_trig_unit
  import dac_fe_pkg::*;
#(
  parameter int NUM_HW = N_HW,
  parameter int LAT    = TRIG_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_en_i,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic [NUM_HW-1:0] hw_trig_i,
  input  logic              swtrig_set_i,
  output logic              hw_evt_o,
  output logic              load_o,
  output logic              swtrig_o
);
  localparam int NSTG = LAT - 1;

  logic            sel_lvl, sel_prev_q;
  logic            sw_mode, load_sw, swtrig_q;
  logic [NSTG-1:0] stg_q;

  assign sw_mode = trig_en_i && (tsel_i == TSEL_SW);
  assign sel_lvl = (int'(tsel_i) < NUM_HW) ? hw_trig_i[tsel_i] : 1'b0;
  assign hw_evt_o = trig_en_i && !sw_mode && sel_lvl && !sel_prev_q;
  assign load_sw  = sw_mode && swtrig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_prev_q <= 1'b0;
      swtrig_q   <= 1'b0;
      stg_q[0]   <= 1'b0;
    end else begin
      sel_prev_q <= sel_lvl;
      stg_q[0]   <= hw_evt_o;
      if (swtrig_set_i)  swtrig_q <= 1'b1;
      else if (load_sw)  swtrig_q <= 1'b0;
    end
  end

  // remaining delay stages of the hardware path
  for (genvar i = 1; i < NSTG; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign load_o   = stg_q[NSTG-1] || load_sw;
  assign swtrig_o = swtrig_q;
endmodule

// File: rtl/dac_dma_ctl.sv
module dac_dma_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_evt_i,
  input  logic dma_en_i,
  input  logic ack_i,
  input  logic udr_clr_i,
  input  logic udr_ie_i,
  output logic req_o,
  output logic udr_o,
  output logic irq_o
);
  logic req_q, udr_q, pending;

  assign pending = req_q && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      req_q <= pending;
      if (udr_clr_i) udr_q <= 1'b0;
      if (hw_evt_i && dma_en_i && !udr_q) begin
        if (pending) begin
          udr_q <= 1'b1;
          req_q <= 1'b0;
        end else begin
          req_q <= 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;
  assign udr_o = udr_q;
  assign irq_o = udr_q && udr_ie_i;
endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top
  import dac_fe_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_trig_en_i,
  input  logic [TSEL_W-1:0] ctrl_tsel_i,
  input  logic              ctrl_dma_en_i,
  input  logic              ctrl_udr_ie_i,
  input  logic              hold_we_i,
  input  logic [2:0]        hold_fmt_i,
  input  logic [BUS_W-1:0]  hold_wdata_i,
  input  logic              swtrig_set_i,
  input  logic [N_HW-1:0]   hw_trig_i,
  input  logic [DATA_W-1:0] wave_add_i,
  input  logic              dma_ack_i,
  input  logic              udr_clr_i,
  output logic [DATA_W-1:0] dor_o,
  output logic              swtrig_o,
  output logic              dma_req_o,
  output logic              udr_flag_o,
  output logic              irq_o
);
  logic              en_q, trig_en_q, dma_en_q, udr_ie_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [DATA_W-1:0] dhr_q, dor_q, hold_val;
  logic              hold_we, hw_evt, load;
  logic [DATA_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      trig_en_q <= 1'b0;
      tsel_q    <= '0;
      dma_en_q  <= 1'b0;
      udr_ie_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      en_q      <= ctrl_en_i;
      trig_en_q <= ctrl_trig_en_i;
      dma_en_q  <= ctrl_dma_en_i;
      udr_ie_q  <= ctrl_udr_ie_i;
      if (!en_q) tsel_q <= ctrl_tsel_i;
    end
  end

  dac_fmt_unpack #(.CH_IDX(CH_IDX)) u_unpack (
    .we_i      (hold_we_i),
    .fmt_i     (hold_fmt_i),
    .wdata_i   (hold_wdata_i),
    .hold_we_o (hold_we),
    .hold_o    (hold_val)
  );

  dac_trig_unit u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_en_i    (trig_en_q),
    .tsel_i       (tsel_q),
    .hw_trig_i    (hw_trig_i),
    .swtrig_set_i (swtrig_set_i),
    .hw_evt_o     (hw_evt),
    .load_o       (load),
    .swtrig_o     (swtrig_o)
  );

  dac_dma_ctl u_dma (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_evt_i  (hw_evt),
    .dma_en_i  (dma_en_q),
    .ack_i     (dma_ack_i),
    .udr_clr_i (udr_clr_i),
    .udr_ie_i  (udr_ie_q),
    .req_o     (dma_req_o),
    .udr_o     (udr_flag_o),
    .irq_o     (irq_o)
  );

  assign sum = {1'b0, dhr_q} + {1'b0, wave_add_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dhr_q <= '0;
      dor_q <= '0;
    end else begin
      if (hold_we) dhr_q <= hold_val;
      if (!trig_en_q)  dor_q <= dhr_q;
      else if (load)   dor_q <= sum[DATA_W] ? '1 : sum[DATA_W-1:0];
    end
  end

  assign dor_o = dor_q;
endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk
  import dac_fe_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] dor_o,
  input logic [DATA_W-1:0] dhr_q,
  input logic              trig_en_q,
  input logic              en_q,
  input logic [TSEL_W-1:0] tsel_q,
  input logic              dma_en_q,
  input logic              dma_req_o,
  input logic              udr_flag_o,
  input logic              udr_clr_i
);
  assert_follow_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_q && $past(!trig_en_q)) |-> dor_o == $past(dhr_q));

  assert_req_needs_dma_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> $past(dma_en_q));

  assert_no_req_in_udr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> !$past(udr_flag_o));

  assert_udr_from_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udr_flag_o) |-> $past(dma_req_o));

  assert_udr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udr_flag_o && !udr_clr_i) |=> udr_flag_o);

  assert_tsel_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(tsel_q));
endmodule

bind dac_fe_top dac_fe_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dor_o      (dor_o),
  .dhr_q      (dhr_q),
  .trig_en_q  (trig_en_q),
  .en_q       (en_q),
  .tsel_q     (tsel_q),
  .dma_en_q   (dma_en_q),
  .dma_req_o  (dma_req_o),
  .udr_flag_o (udr_flag_o),
  .udr_clr_i  (udr_clr_i)
);

// File: tb/dac_fe_top_tb_top.sv
module dac_fe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 0, c_en = 0, c_ten = 0, c_dma = 0, c_ie = 0;
  logic [2:0]  c_tsel = 0;
  logic        h_we = 0;
  logic [2:0]  h_fmt = 0;
  logic [31:0] h_wd = 0;
  logic        sw_set = 0;
  logic [6:0]  hw = 0;
  logic [11:0] wave = 0;
  logic        ack = 0, uclr = 0;
  logic [11:0] dor0, dor1;
  logic        sw0, req0, udr0, irq0, sw1, req1, udr1, irq1;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dac_fe_top #(.CH_IDX(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_en_i(c_en),
    .ctrl_trig_en_i(c_ten), .ctrl_tsel_i(c_tsel), .ctrl_dma_en_i(c_dma),
    .ctrl_udr_ie_i(c_ie), .hold_we_i(h_we), .hold_fmt_i(h_fmt),
    .hold_wdata_i(h_wd), .swtrig_set_i(sw_set), .hw_trig_i(hw),
    .wave_add_i(wave), .dma_ack_i(ack), .udr_clr_i(uclr), .dor_o(dor0),
    .swtrig_o(sw0), .dma_req_o(req0), .udr_flag_o(udr0), .irq_o(irq0));

  dac_fe_top #(.CH_IDX(1)) dut_ch2_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_en_i(c_en),
    .ctrl_trig_en_i(c_ten), .ctrl_tsel_i(c_tsel), .ctrl_dma_en_i(c_dma),
    .ctrl_udr_ie_i(c_ie), .hold_we_i(h_we), .hold_fmt_i(h_fmt),
    .hold_wdata_i(h_wd), .swtrig_set_i(sw_set), .hw_trig_i(hw),
    .wave_add_i(wave), .dma_ack_i(ack), .udr_clr_i(uclr), .dor_o(dor1),
    .swtrig_o(sw1), .dma_req_o(req1), .udr_flag_o(udr1), .irq_o(irq1));

  // {format, write word, expected ch1 holding, expected ch2 holding}
  localparam logic [58:0] VEC [7] = '{
    {3'd0, 32'hFFFF_F5A3, 12'h5A3, 12'h5A3},
    {3'd1, 32'h0000_ABCD, 12'hABC, 12'hABC},
    {3'd2, 32'h0000_12F7, 12'hF70, 12'hF70},
    {3'd3, 32'h0ABC_0123, 12'h123, 12'hABC},
    {3'd4, 32'hDEF0_4560, 12'h456, 12'hDEF},
    {3'd5, 32'h0000_C35A, 12'h5A0, 12'hC30},
    {3'd6, 32'h0000_0FFF, 12'h5A0, 12'hC30}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctrl(logic en, logic ten, logic [2:0] ts, logic dma, logic ie);
    c_en = en; c_ten = ten; c_tsel = ts; c_dma = dma; c_ie = ie;
    ctrl_we = 1'b1;
    tick();
    ctrl_we = 1'b0;
  endtask

  task automatic wr12(logic [11:0] v);
    h_fmt = 3'd0; h_wd = {20'h0, v}; h_we = 1'b1;
    tick();
    h_we = 1'b0;
  endtask

  task automatic swpulse();
    sw_set = 1'b1;
    tick();
    sw_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dor", dor0, 12'h0);
    chk("R1 flags", {7'd0, sw0, req0, udr0, irq0}, 12'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {dor0[10:0], req0}, 12'h0);

    // R2/R3/R4 vector walk, wave add must be ignored with trigger off
    wave = 12'h055;
    for (int i = 0; i < 7; i++) begin
      h_fmt = VEC[i][58:56]; h_wd = VEC[i][55:24]; h_we = 1'b1;
      tick();
      h_we = 1'b0;
      tick();
      chk(i < 3 || i == 6 ? "R2 R4 ch1" : "R3 R4 ch1", dor0, VEC[i][23:12]);
      chk(i < 3 || i == 6 ? "R2 R4 ch2" : "R3 R4 ch2", dor1, VEC[i][11:0]);
    end
    wave = 12'h000;

    ctrl(1, 1, 3'd2, 1, 1);
    wr12(12'h321);
    tick();
    chk("R5 no trigger no load", dor0, 12'h5A0);

    hw[0] = 1'b1; tick(); hw[0] = 1'b0;
    repeat (3) tick();
    chk("R5 unselected source", dor0, 12'h5A0);
    chk("R8 unselected no req", {11'd0, req0}, 12'h0);

    hw[2] = 1'b1;
    tick();
    chk("R8 req after edge", {11'd0, req0}, 12'h1);
    tick();
    chk("R5 not yet loaded", dor0, 12'h5A0);
    tick();
    chk("R5 load third edge", dor0, 12'h321);
    wr12(12'h3AA);
    repeat (4) tick();
    chk("R5 level no reload", dor0, 12'h321);
    chk("R9 level no underrun", {11'd0, udr0}, 12'h0);

    ack = 1'b1; tick(); ack = 1'b0;
    chk("R8 ack clears", {11'd0, req0}, 12'h0);

    hw[2] = 1'b0; tick();
    hw[2] = 1'b1; tick();
    chk("R8 second req", {11'd0, req0}, 12'h1);
    hw[2] = 1'b0;
    h_fmt = 3'd0; h_wd = 32'h222; h_we = 1'b1;
    tick();
    h_we = 1'b0;
    hw[2] = 1'b1; tick();
    chk("R9 underrun flag", {10'd0, udr0, req0}, 12'h2);
    chk("R10 irq", {11'd0, irq0}, 12'h1);
    tick();
    tick();
    chk("R9 keeps converting", dor0, 12'h222);
    hw[2] = 1'b0; tick();
    hw[2] = 1'b1; tick();
    chk("R9 no req while flagged", {11'd0, req0}, 12'h0);

    uclr = 1'b1; tick(); uclr = 1'b0;
    chk("R10 clear flag", {10'd0, udr0, irq0}, 12'h0);
    hw[2] = 1'b0; tick();
    hw[2] = 1'b1; tick();
    chk("R8 req after clear", {11'd0, req0}, 12'h1);
    ack = 1'b1; tick(); ack = 1'b0;
    hw[2] = 1'b0; repeat (3) tick();

    // R11: select change refused while enabled
    ctrl(1, 1, 3'd0, 0, 1);
    wr12(12'h444);
    hw[0] = 1'b1; tick(); hw[0] = 1'b0;
    repeat (3) tick();
    chk("R11 old select kept", dor0, 12'h222);
    hw[2] = 1'b1; repeat (3) tick(); hw[2] = 1'b0;
    chk("R11 old select loads", dor0, 12'h444);
    tick();

    // R6 software trigger
    ctrl(0, 1, 3'd2, 1, 1);
    ctrl(1, 1, 3'd7, 1, 1);
    wr12(12'h7E5);
    swpulse();
    chk("R6 bit set", {11'd0, sw0}, 12'h1);
    chk("R6 not loaded yet", dor0, 12'h444);
    tick();
    chk("R6 one clock load", dor0, 12'h7E5);
    chk("R6 bit cleared", {11'd0, sw0}, 12'h0);
    chk("R8 sw no req", {11'd0, req0}, 12'h0);

    // R7 add-on value with saturation
    wave = 12'h100;
    swpulse(); tick();
    chk("R7 sum", dor0, 12'h8E5);
    wave = 12'h900;
    swpulse(); tick();
    chk("R7 saturate", dor0, 12'hFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule